// File: doc/BRIEF.md
# Pipelined Order Dispatcher

This block drives a solver datapath from a stored program. Each order is one formula: three operand addresses, one result address, an operation code and a valid flag. After a step-start pulse the block fetches one order per clock from an external order memory and hands the fields to three consumers. The operand read controller gets them at once. The operation-select controller gets them after the data-storage read latency. The result write controller gets them exactly when that operation's arithmetic pipeline delivers its result.

Write-back alignment uses a slot array indexed by the time left until write. Every order drops its write into the slot its own latency points at. Short and long operations therefore share one structure and nothing stalls. After the last order of the program is fetched the program counter wraps to zero and fetching stops until the next step begins. A done pulse marks the cycle in which the last order's write slot comes out.

Top module: `order_dispatch`

## Requirements
- R1: While rst_ni is low, om_rd_o, rd_valid_o, sel_valid_o, wr_en_o and step_done_o are all 0.
- R2: A step_start_i pulse sampled at edge E starts a fetch of address 0 in the cycle after E, and the address rises by one each cycle. The memory returns data one cycle after the request. The fields of order k appear on rd_src_a_o/rd_src_b_o/rd_src_c_o with rd_valid_o two cycles after its fetch.
- R3: sel_valid_o and sel_op_o repeat rd_valid_o and the opcode RD_LAT cycles (default 1) after the read outputs.
- R4: Order word layout, LSB first: src_a [9:0], src_b [19:10], src_c [29:20], dst [39:30], opcode [42:40], valid [43]. A valid order raises wr_en_o with wr_addr_o = dst exactly RD_LAT + L cycles after its read outputs. L is 4 for opcode 0 (add), 4 for 1 (mul), 14 for 2 (div) and 8 for 3 (multiply-add).
- R5: An order with valid = 0 is a bubble. It raises none of rd_valid_o, sel_valid_o or wr_en_o.
- R6: A valid order with opcode 4 to 7 is read and selected as usual but produces no write enable.
- R7: step_done_o pulses for one cycle when the write slot of order ORDER_CNT-1 comes out. That is RD_LAT + L cycles after its read outputs, with L = 1 for opcodes 4 to 7.
- R8: After address ORDER_CNT-1 is fetched, om_rd_o drops and stays low until the next step_start_i. A new step replays the same program with the same timing.
- R9: A step_start_i during a running step restarts fetching at address 0 on the next cycle. Orders already fetched still complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_start_i | input | 1 | Starts a simulation step at order 0 |
| om_rd_o | output | 1 | Order memory read request |
| om_addr_o | output | $clog2(ORDER_CNT) | Order memory address |
| om_data_i | input | 4*ADDR_W+4 | Order word, valid one cycle after the request |
| rd_valid_o | output | 1 | Operand read fields valid |
| rd_src_a_o | output | ADDR_W | First operand address |
| rd_src_b_o | output | ADDR_W | Second operand address |
| rd_src_c_o | output | ADDR_W | Third operand address |
| sel_valid_o | output | 1 | Operation select valid |
| sel_op_o | output | 3 | Operation code to the arithmetic core |
| wr_en_o | output | 1 | Result write enable |
| wr_addr_o | output | ADDR_W | Result address |
| step_done_o | output | 1 | Last order's write slot reached |

## Verification
Counting edges from the step-start edge E: order k's fetch is due at E+k, its read fields at E+k+2, its select at E+k+3, and its write and any done pulse at E+k+3+L. The bench builds a per-cycle table of expected outputs from these offsets and the program vector table. It then compares every output on the falling edge of each cycle across a 48-cycle window. This covers the idle slots where a bubble or an unknown opcode would have written. Directed cases check reset in the middle of a step and a restart timed against a known fetch edge.

// File: rtl/order_dispatch_pkg.sv
`timescale 1ns/1ps
package order_dispatch_pkg;
  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_MUL = 3'd1;
  localparam logic [2:0] OP_DIV = 3'd2;
  localparam logic [2:0] OP_MAC = 3'd3;

  localparam int LAT_ADD = 4;
  localparam int LAT_MUL = 4;
  localparam int LAT_DIV = 14;
  localparam int LAT_MAC = 8;
  localparam int LAT_NOP = 1;
  localparam int LAT_MAX = 14;

  function automatic int op_lat(logic [2:0] op);
    case (op)
      OP_ADD:  return LAT_ADD;
      OP_MUL:  return LAT_MUL;
      OP_DIV:  return LAT_DIV;
      OP_MAC:  return LAT_MAC;
      default: return LAT_NOP;
    endcase
  endfunction

  function automatic logic op_writes(logic [2:0] op);
    return op inside {OP_ADD, OP_MUL, OP_DIV, OP_MAC};
  endfunction
endpackage

// File: rtl/odisp_fetch.sv
`timescale 1ns/1ps
module odisp_fetch #(
  parameter int ORDER_CNT = 16,
  parameter int PC_W      = $clog2(ORDER_CNT)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_start_i,
  output logic            rd_o,
  output logic [PC_W-1:0] addr_o,
  output logic            data_vld_o,
  output logic            data_last_o
);
  localparam logic [PC_W-1:0] LAST = PC_W'(ORDER_CNT - 1);

  logic            run_q;
  logic [PC_W-1:0] pc_q;
  logic            vld_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      pc_q   <= '0;
      vld_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      vld_q  <= run_q;
      last_q <= run_q && (pc_q == LAST);
      if (step_start_i) begin
        run_q <= 1'b1;
        pc_q  <= '0;
      end else if (run_q) begin
        if (pc_q == LAST) begin
          run_q <= 1'b0;
          pc_q  <= '0;
        end else begin
          pc_q <= pc_q + 1'b1;
        end
      end
    end
  end

  assign rd_o        = run_q;
  assign addr_o      = pc_q;
  assign data_vld_o  = vld_q;
  assign data_last_o = last_q;
endmodule

// File: rtl/odisp_sel_pipe.sv
`timescale 1ns/1ps
module odisp_sel_pipe #(
  parameter int RD_LAT = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       v_i,
  input  logic [2:0] op_i,
  output logic       v_o,
  output logic [2:0] op_o
);
  if (RD_LAT == 0) begin : g_pass
    assign v_o  = v_i;
    assign op_o = op_i;
  end else begin : g_pipe
    logic       v_q  [RD_LAT];
    logic [2:0] op_q [RD_LAT];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < RD_LAT; i++) begin
          v_q[i]  <= 1'b0;
          op_q[i] <= '0;
        end
      end else begin
        v_q[0]  <= v_i;
        op_q[0] <= op_i;
        for (int i = 1; i < RD_LAT; i++) begin
          v_q[i]  <= v_q[i-1];
          op_q[i] <= op_q[i-1];
        end
      end
    end
    assign v_o  = v_q[RD_LAT-1];
    assign op_o = op_q[RD_LAT-1];
  end
endmodule

// File: rtl/odisp_wb_align.sv
`timescale 1ns/1ps
module odisp_wb_align #(
  parameter int ADDR_W = 10,
  parameter int DEPTH  = 16,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ins_i,
  input  logic [IDX_W-1:0]  ins_idx_i,
  input  logic              ins_we_i,
  input  logic              ins_last_i,
  input  logic [ADDR_W-1:0] ins_addr_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              done_o,
  output logic              collide_o
);
  typedef struct packed {
    logic              we;
    logic              last;
    logic [ADDR_W-1:0] addr;
  } slot_t;

  slot_t slot_q [DEPTH];
  slot_t shf    [DEPTH];
  slot_t nxt    [DEPTH];

  // slot k comes out k edges from now
  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      shf[k] = (k == DEPTH - 1) ? '0 : slot_q[(k == DEPTH - 1) ? k : k + 1];
      nxt[k] = shf[k];
    end
    collide_o = 1'b0;
    if (ins_i) begin
      collide_o          = ins_we_i && shf[ins_idx_i].we;
      nxt[ins_idx_i].we   = shf[ins_idx_i].we | ins_we_i;
      nxt[ins_idx_i].last = shf[ins_idx_i].last | ins_last_i;
      if (ins_we_i) nxt[ins_idx_i].addr = ins_addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) slot_q[k] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) slot_q[k] <= nxt[k];
    end
  end

  assign wr_en_o   = slot_q[0].we;
  assign wr_addr_o = slot_q[0].addr;
  assign done_o    = slot_q[0].last;
endmodule

// File: rtl/order_dispatch.sv
`timescale 1ns/1ps
module order_dispatch
  import order_dispatch_pkg::*;
#(
  parameter int ORDER_CNT = 16,
  parameter int ADDR_W    = 10,
  parameter int RD_LAT    = 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         step_start_i,
  output logic                         om_rd_o,
  output logic [$clog2(ORDER_CNT)-1:0] om_addr_o,
  input  logic [4*ADDR_W+3:0]          om_data_i,
  output logic                         rd_valid_o,
  output logic [ADDR_W-1:0]            rd_src_a_o,
  output logic [ADDR_W-1:0]            rd_src_b_o,
  output logic [ADDR_W-1:0]            rd_src_c_o,
  output logic                         sel_valid_o,
  output logic [2:0]                   sel_op_o,
  output logic                         wr_en_o,
  output logic [ADDR_W-1:0]            wr_addr_o,
  output logic                         step_done_o
);
  localparam int PC_W  = $clog2(ORDER_CNT);
  localparam int DEPTH = RD_LAT + LAT_MAX + 1;
  localparam int IDX_W = $clog2(DEPTH);

  logic              f_v;
  logic [2:0]        f_op;
  logic [ADDR_W-1:0] f_a, f_b, f_c, f_dst;

  assign f_a   = om_data_i[ADDR_W-1:0];
  assign f_b   = om_data_i[2*ADDR_W-1:ADDR_W];
  assign f_c   = om_data_i[3*ADDR_W-1:2*ADDR_W];
  assign f_dst = om_data_i[4*ADDR_W-1:3*ADDR_W];
  assign f_op  = om_data_i[4*ADDR_W+2:4*ADDR_W];
  assign f_v   = om_data_i[4*ADDR_W+3];

  logic data_vld, data_last;

  odisp_fetch #(.ORDER_CNT(ORDER_CNT), .PC_W(PC_W)) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_start_i(step_start_i),
    .rd_o        (om_rd_o),
    .addr_o      (om_addr_o),
    .data_vld_o  (data_vld),
    .data_last_o (data_last)
  );

  logic       iss_v_q;
  logic [2:0] iss_op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iss_v_q    <= 1'b0;
      iss_op_q   <= '0;
      rd_src_a_o <= '0;
      rd_src_b_o <= '0;
      rd_src_c_o <= '0;
    end else begin
      iss_v_q <= data_vld && f_v;
      if (data_vld) begin
        iss_op_q   <= f_op;
        rd_src_a_o <= f_a;
        rd_src_b_o <= f_b;
        rd_src_c_o <= f_c;
      end
    end
  end

  assign rd_valid_o = iss_v_q;

  odisp_sel_pipe #(.RD_LAT(RD_LAT)) u_sel (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .v_i   (iss_v_q),
    .op_i  (iss_op_q),
    .v_o   (sel_valid_o),
    .op_o  (sel_op_o)
  );

  // write lands RD_LAT + latency cycles after the read outputs
  logic [IDX_W-1:0] ins_idx;
  logic             wb_collide;

  assign ins_idx = IDX_W'(RD_LAT + op_lat(f_op));

  odisp_wb_align #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_wb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ins_i     (data_vld),
    .ins_idx_i (ins_idx),
    .ins_we_i  (f_v && op_writes(f_op)),
    .ins_last_i(data_last),
    .ins_addr_i(f_dst),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .done_o    (step_done_o),
    .collide_o (wb_collide)
  );
endmodule

// File: rtl/order_dispatch_chk.sv
`timescale 1ns/1ps
module order_dispatch_chk #(
  parameter int ORDER_CNT = 16,
  parameter int RD_LAT    = 1
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         step_start_i,
  input logic                         om_rd_o,
  input logic [$clog2(ORDER_CNT)-1:0] om_addr_o,
  input logic                         rd_valid_o,
  input logic                         sel_valid_o,
  input logic                         wr_en_o,
  input logic                         step_done_o,
  input logic                         wb_collide
);
  localparam logic [$clog2(ORDER_CNT)-1:0] LAST = ($clog2(ORDER_CNT))'(ORDER_CNT - 1);

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni)
      reset_quiet_chk: assert (!om_rd_o && !rd_valid_o && !sel_valid_o && !wr_en_o && !step_done_o);
  end

  // R2
  start_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_start_i |=> (om_rd_o && om_addr_o == '0));

  // R3
  sel_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> ##RD_LAT sel_valid_o);

  // R8
  stop_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (om_rd_o && om_addr_o == LAST && !step_start_i) |=> !om_rd_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_done_o |=> !step_done_o);

  // R4
  no_wb_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wb_collide);
endmodule

bind order_dispatch order_dispatch_chk #(.ORDER_CNT(ORDER_CNT), .RD_LAT(RD_LAT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .step_start_i(step_start_i),
  .om_rd_o     (om_rd_o),
  .om_addr_o   (om_addr_o),
  .rd_valid_o  (rd_valid_o),
  .sel_valid_o (sel_valid_o),
  .wr_en_o     (wr_en_o),
  .step_done_o (step_done_o),
  .wb_collide  (wb_collide)
);

// File: tb/order_dispatch_tb.sv
`timescale 1ns/1ps
module order_dispatch_tb;
  localparam int N   = 12;
  localparam int AW  = 10;
  localparam int OW  = 4*AW + 4;
  localparam int WIN = 48;

  // program vector table: {valid, opcode, dst}
  localparam logic [13:0] PROG [N] = '{
    {1'b1, 3'd2, 10'd100}, {1'b1, 3'd0, 10'd101}, {1'b1, 3'd1, 10'd102},
    {1'b1, 3'd3, 10'd103}, {1'b0, 3'd0, 10'd104}, {1'b1, 3'd0, 10'd105},
    {1'b1, 3'd2, 10'd106}, {1'b1, 3'd5, 10'd107}, {1'b1, 3'd1, 10'd108},
    {1'b1, 3'd3, 10'd109}, {1'b1, 3'd3, 10'd110}, {1'b1, 3'd2, 10'd111}
  };

  logic clk = 1'b0, rst_n = 1'b1, start = 1'b0;
  logic om_rd, rd_v, sel_v, wr_en, done;
  logic [3:0] om_addr;
  logic [OW-1:0] om_data;
  logic [AW-1:0] ra, rb, rc, wa;
  logic [2:0] sop;
  logic [OW-1:0] omem [N];

  int cyc = 0, total = 0, bad = 0;
  bit fin = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always_ff @(posedge clk) if (om_rd) om_data <= omem[om_addr];

  order_dispatch #(.ORDER_CNT(N), .ADDR_W(AW), .RD_LAT(1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .step_start_i(start),
    .om_rd_o(om_rd), .om_addr_o(om_addr), .om_data_i(om_data),
    .rd_valid_o(rd_v), .rd_src_a_o(ra), .rd_src_b_o(rb), .rd_src_c_o(rc),
    .sel_valid_o(sel_v), .sel_op_o(sop),
    .wr_en_o(wr_en), .wr_addr_o(wa), .step_done_o(done)
  );

  function automatic int lat_of(logic [2:0] op);
    case (op)
      3'd0, 3'd1: return 4;
      3'd2:       return 14;
      3'd3:       return 8;
      default:    return 1;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cyc=%0d act=%0d exp=%0d", req, cyc, act, exp);
    end
  endtask

  bit e_or [WIN], e_rv [WIN], e_sv [WIN], e_we [WIN], e_dn [WIN];
  int e_oa [WIN], e_ra [WIN], e_rb [WIN], e_rc [WIN], e_op [WIN], e_wa [WIN];

  task automatic build_exp();
    for (int t = 0; t < WIN; t++) begin
      e_or[t] = 0; e_rv[t] = 0; e_sv[t] = 0; e_we[t] = 0; e_dn[t] = 0;
      e_oa[t] = 0; e_ra[t] = 0; e_rb[t] = 0; e_rc[t] = 0; e_op[t] = 0; e_wa[t] = 0;
    end
    for (int k = 0; k < N; k++) begin
      logic v; logic [2:0] op; int w;
      v  = PROG[k][13];
      op = PROG[k][12:10];
      w  = k + 3 + lat_of(op);
      e_or[k] = 1; e_oa[k] = k;
      e_rv[k+2] = v; e_ra[k+2] = 16 + k; e_rb[k+2] = 300 + k; e_rc[k+2] = 600 + k;
      e_sv[k+3] = v; e_op[k+3] = op;
      if (v && op < 3'd4) begin e_we[w] = 1; e_wa[w] = PROG[k][9:0]; end
      if (k == N - 1) e_dn[w] = 1;
    end
  endtask

  task automatic run_step();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int t = 0; t < WIN; t++) begin
      chk(om_rd == e_or[t], "R8 om_rd", om_rd, e_or[t]);
      if (e_or[t]) chk(om_addr == e_oa[t], "R2 om_addr", om_addr, e_oa[t]);
      chk(rd_v == e_rv[t], "R5 rd_valid", rd_v, e_rv[t]);
      if (e_rv[t]) begin
        chk(ra == e_ra[t], "R2 src_a", ra, e_ra[t]);
        chk(rb == e_rb[t], "R2 src_b", rb, e_rb[t]);
        chk(rc == e_rc[t], "R2 src_c", rc, e_rc[t]);
      end
      chk(sel_v == e_sv[t], "R3 sel_valid", sel_v, e_sv[t]);
      if (e_sv[t]) chk(sop == e_op[t], "R3 sel_op", sop, e_op[t]);
      chk(wr_en == e_we[t], "R4 wr_en", wr_en, e_we[t]);
      if (e_we[t]) chk(wa == e_wa[t], "R4 wr_addr", wa, e_wa[t]);
      // slot where bubble order 4 and unknown-opcode order 7 would write
      if (t == 11) begin
        chk(!wr_en, "R5 bubble no write", wr_en, 0);
        chk(!wr_en, "R6 unknown op no write", wr_en, 0);
      end
      chk(done == e_dn[t], "R7 step_done", done, e_dn[t]);
      @(negedge clk);
    end
  endtask

  task automatic chk_quiet(string req);
    chk(!om_rd, req, om_rd, 0);
    chk(!rd_v,  req, rd_v, 0);
    chk(!sel_v, req, sel_v, 0);
    chk(!wr_en, req, wr_en, 0);
    chk(!done,  req, done, 0);
  endtask

  initial begin
    for (int k = 0; k < N; k++)
      omem[k] = {PROG[k], AW'(600 + k), AW'(300 + k), AW'(16 + k)};
    om_data = '0;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_quiet("R1 reset state");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_quiet("R8 idle without start");

    build_exp();
    run_step();
    run_step();   // R8 replay

    // R9 restart while running
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (3) @(negedge clk);
    chk(om_addr == 4'd3, "R9 pre-restart addr", om_addr, 3);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(om_rd && om_addr == 4'd0, "R9 restart addr", om_addr, 0);
    @(negedge clk);
    @(negedge clk);
    chk(rd_v && ra == AW'(16), "R9 order0 reissued", ra, 16);
    repeat (40) @(negedge clk);

    // R1 reset in the middle of a step
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk_quiet("R1 mid-step reset");
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk_quiet("R8 no fetch after reset");

    fin = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog expired cyc=%0d act=0 exp=1", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule